// File: doc/BRIEF.md
# Load-Predictive Clock Governor

This block is a periodic controller that sets one chip-wide clock divider for a many-core stream-processing fabric. At every sample tick it takes the input message rate, the output message rate and the number of idle workers. From the two rates it forms an instantaneous overload ratio, (input − output) / input, using a sequential divider. It smooths that ratio and the idle-worker count with two exponential moving averages, each with its own programmable weight.

The two predictions are compared against programmable thresholds. A high idle prediction slows the fabric down by one divider step, whatever the overload is. A speedup needs two things at once: few idle workers and a predicted overload above its threshold. In every other case the setting is held.

The divider selects a fraction of a 1600 MHz reference, from 2 (800 MHz) up to 16 (100 MHz). Changes are spaced a minimum number of samples apart. Each change is handed to a downstream voltage/frequency sequencer as a one-cycle request. No further change is made until the sequencer reports completion.

Top module: `dvfs_governor`

## Requirements
- R1: The instantaneous overload is a signed Q1.8 value, bits [9:0]: floor(|in − out|·256 / in) with the sign of (in − out); a negative magnitude above 512 saturates to −512 (−2.0), and an input rate of 0 gives 0.
- R2: The first sample after reset leaves both predictions at 0.
- R3: On each later sample, each prediction becomes floor((a·cur + (256 − a)·prev) / 256), where a is that predictor's own 8-bit weight. The idle current value is the idle count in Q8.4, that is count·16. Between samples the predictions do not change.
- R4: When the idle prediction is greater than the idle threshold (unsigned Q8.4), the target divider is the current divider + 1.
- R5: When the idle prediction is at or below the idle threshold and the overload prediction is greater than the signed Q1.8 overload threshold, the target divider is the current divider − 1; otherwise the divider is held.
- R6: The target is clamped to the range 2..16, and a clamped target equal to the current divider makes no change and no request.
- R7: A change updates div_o and raises div_req_o for exactly one cycle in the same cycle; div_o never changes without a request and never moves by more than one step.
- R8: After a change, the next GAP − 1 samples (GAP = 3 by default) cannot change the divider; the first sample after reset may change it.
- R9: After a request, samples are held until seq_done_i is seen. seq_done_i while no request is outstanding has no effect.
- R10: Reset sets div_o to 2, both predictions to 0 and div_req_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample strobe; ignored while a sample is being computed |
| in_rate_i | input | 16 | Input message rate for this sample |
| out_rate_i | input | 16 | Output message rate for this sample |
| idle_cnt_i | input | 8 | Idle workers in this sample |
| ovl_alpha_i | input | 8 | Overload smoothing weight, Q0.8 |
| idle_alpha_i | input | 8 | Idle smoothing weight, Q0.8 |
| ovl_thr_i | input | 10 | Overload threshold, signed Q1.8 |
| idle_thr_i | input | 12 | Idle threshold, unsigned Q8.4 |
| seq_done_i | input | 1 | Sequencer finished applying the last request |
| div_o | output | 5 | Current global clock divider |
| div_req_o | output | 1 | One-cycle change request |
| ovl_pred_o | output | 10 | Overload prediction, signed Q1.8 |
| idle_pred_o | output | 12 | Idle prediction, Q8.4 |

## Verification
The hardest state to reach is a decision that arrives while a request is still outstanding and the gap window has already expired. Only then can the done handshake be the one thing that holds the divider. The stimulus holds seq_done_i back across a run of high-idle samples, so that each sample is suppressed by the wait and not by the gap. It then releases done and sees stepping resume. The two clamp ends are reached by long runs of saturating idle and overload. A random sweep, with done sometimes withheld, then mixes weights, thresholds, zero input rates and out-greater-than-in saturation.

// File: rtl/dvfs_gov_pkg.sv
package dvfs_gov_pkg;
  localparam int unsigned REF_MHZ = 1600;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_FAST = 2'd1,
    ACT_SLOW = 2'd2
  } act_e;
endpackage

// File: rtl/dvfs_ratio_div.sv
module dvfs_ratio_div #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_W - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W-1:0] rem_q, rem_nxt;
  logic [NUM_W-1:0] quo_q, quo_nxt;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W:0]   rem_sh, diff;
  logic             fit;

  always_comb begin
    rem_sh  = {rem_q, quo_q[NUM_W-1]};
    diff    = rem_sh - {1'b0, den_q};
    fit     = rem_sh >= {1'b0, den_q};
    rem_nxt = fit ? diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
    quo_nxt = {quo_q[NUM_W-2:0], fit};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        rem_q  <= '0;
        quo_q  <= num_i;
        den_q  <= den_i;
      end else if (busy_q) begin
        rem_q <= rem_nxt;
        quo_q <= quo_nxt;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo_q;

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R1
endmodule

// File: rtl/dvfs_ema.sv
module dvfs_ema #(
  parameter int W   = 10,
  parameter int A_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_i,
  input  logic [A_W-1:0]      alpha_i,
  input  logic signed [W-1:0] cur_i,
  output logic signed [W-1:0] pred_o
);
  localparam int ACC_W = W + A_W + 3;

  logic                    first_q;
  logic signed [W-1:0]     pred_q;
  logic signed [ACC_W-1:0] a_s, b_s, c_s, p_s, acc, shf;

  always_comb begin
    a_s = $signed({{(ACC_W-A_W){1'b0}}, alpha_i});
    b_s = $signed(ACC_W'(1 << A_W)) - a_s;
    c_s = $signed({{(ACC_W-W){cur_i[W-1]}}, cur_i});
    p_s = $signed({{(ACC_W-W){pred_q[W-1]}}, pred_q});
    acc = a_s * c_s + b_s * p_s;
    shf = acc >>> A_W;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      pred_q  <= '0;
    end else if (upd_i) begin
      first_q <= 1'b0;
      pred_q  <= first_q ? '0 : shf[W-1:0];
    end
  end

  assign pred_o = pred_q;

  AST_FIRST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && first_q) |=> (pred_o == '0)); // R2
  AST_PRED_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(pred_o)); // R3
endmodule

// File: rtl/dvfs_step_ctl.sv
module dvfs_step_ctl
  import dvfs_gov_pkg::*;
#(
  parameter int OVL_W   = 10,
  parameter int IDLE_W  = 12,
  parameter int DIV_W   = 5,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 16,
  parameter int GAP     = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   eval_i,
  input  logic signed [OVL_W-1:0] ovl_pred_i,
  input  logic [IDLE_W-1:0]      idle_pred_i,
  input  logic signed [OVL_W-1:0] ovl_thr_i,
  input  logic [IDLE_W-1:0]      idle_thr_i,
  input  logic                   done_i,
  output logic [DIV_W-1:0]       div_o,
  output logic                   req_o
);
  localparam int CNT_W = $clog2(GAP + 1);
  localparam logic [CNT_W-1:0] GAP_LIM = CNT_W'(GAP - 1);
  localparam logic [DIV_W-1:0] D_MIN = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] D_MAX = DIV_W'(DIV_MAX);

  act_e             act;
  logic [DIV_W-1:0] div_q, tgt;
  logic [CNT_W-1:0] gap_q;
  logic             wait_q, req_q, change;

  always_comb begin
    if (idle_pred_i > idle_thr_i)      act = ACT_SLOW;
    else if (ovl_pred_i > ovl_thr_i)   act = ACT_FAST;
    else                               act = ACT_HOLD;
    unique case (act)
      ACT_SLOW: tgt = (div_q >= D_MAX) ? D_MAX : div_q + 1'b1;
      ACT_FAST: tgt = (div_q <= D_MIN) ? D_MIN : div_q - 1'b1;
      default:  tgt = div_q;
    endcase
    change = eval_i && !wait_q && (gap_q >= GAP_LIM) && (tgt != div_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= D_MIN;
      gap_q  <= GAP_LIM;
      wait_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= change;
      if (change) begin
        div_q  <= tgt;
        gap_q  <= '0;
        wait_q <= 1'b1;
      end else begin
        if (eval_i && gap_q < GAP_LIM) gap_q <= gap_q + 1'b1;
        if (done_i) wait_q <= 1'b0;
      end
    end
  end

  assign div_o = div_q;
  assign req_o = req_q;

  AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o >= D_MIN) && (div_o <= D_MAX)); // R6
  AST_REQ_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (div_o != $past(div_o))); // R7
  AST_QUIET_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> $stable(div_o)); // R7
  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ((div_o == $past(div_o) + 1'b1) || (div_o + 1'b1 == $past(div_o)))); // R7
  AST_WAIT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && !done_i) |=> !req_o); // R9
endmodule

// File: rtl/dvfs_governor.sv
module dvfs_governor #(
  parameter int RATE_W  = 16,
  parameter int IDLE_W  = 8,
  parameter int FRAC_W  = 8,
  parameter int DIV_W   = 5,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 16,
  parameter int GAP     = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic [RATE_W-1:0]        in_rate_i,
  input  logic [RATE_W-1:0]        out_rate_i,
  input  logic [IDLE_W-1:0]        idle_cnt_i,
  input  logic [FRAC_W-1:0]        ovl_alpha_i,
  input  logic [FRAC_W-1:0]        idle_alpha_i,
  input  logic [FRAC_W+1:0]        ovl_thr_i,
  input  logic [IDLE_W+3:0]        idle_thr_i,
  input  logic                     seq_done_i,
  output logic [DIV_W-1:0]         div_o,
  output logic                     div_req_o,
  output logic [FRAC_W+1:0]        ovl_pred_o,
  output logic [IDLE_W+3:0]        idle_pred_o
);
  localparam int OVL_W = FRAC_W + 2;
  localparam int IP_W  = IDLE_W + 4;
  localparam int NUM_W = RATE_W + FRAC_W;
  localparam logic [NUM_W-1:0] NEG_LIM = NUM_W'(1 << (FRAC_W + 1));

  logic              busy_q, zero_q, neg_q, eval_q;
  logic [IDLE_W-1:0] idle_q;
  logic              start, div_done;
  logic [RATE_W-1:0] mag;
  logic [NUM_W-1:0]  quo, mag_sat, neg_v;
  logic signed [OVL_W-1:0] ovl_cur, ovl_pred;
  logic signed [IP_W:0]    idle_cur, idle_pred;

  assign start = tick_i && !busy_q;
  assign mag   = (out_rate_i > in_rate_i) ? out_rate_i - in_rate_i : in_rate_i - out_rate_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      zero_q <= 1'b0;
      neg_q  <= 1'b0;
      idle_q <= '0;
      eval_q <= 1'b0;
    end else begin
      eval_q <= div_done;
      if (start) begin
        busy_q <= 1'b1;
        zero_q <= (in_rate_i == '0);
        neg_q  <= (out_rate_i > in_rate_i);
        idle_q <= idle_cnt_i;
      end else if (div_done) begin
        busy_q <= 1'b0;
      end
    end
  end

  dvfs_ratio_div #(.NUM_W(NUM_W), .DEN_W(RATE_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .num_i  ({mag, {FRAC_W{1'b0}}}),
    .den_i  (in_rate_i),
    .done_o (div_done),
    .quo_o  (quo)
  );

  always_comb begin
    mag_sat = (quo > NEG_LIM) ? NEG_LIM : quo;
    neg_v   = NUM_W'(0) - mag_sat;
    if (zero_q)     ovl_cur = '0;
    else if (neg_q) ovl_cur = $signed(neg_v[OVL_W-1:0]);
    else            ovl_cur = $signed(quo[OVL_W-1:0]);
    idle_cur = $signed({1'b0, idle_q, 4'b0000});
  end

  dvfs_ema #(.W(OVL_W), .A_W(FRAC_W)) u_ema_ovl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (div_done),
    .alpha_i(ovl_alpha_i),
    .cur_i  (ovl_cur),
    .pred_o (ovl_pred)
  );

  dvfs_ema #(.W(IP_W + 1), .A_W(FRAC_W)) u_ema_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (div_done),
    .alpha_i(idle_alpha_i),
    .cur_i  (idle_cur),
    .pred_o (idle_pred)
  );

  dvfs_step_ctl #(
    .OVL_W  (OVL_W),
    .IDLE_W (IP_W),
    .DIV_W  (DIV_W),
    .DIV_MIN(DIV_MIN),
    .DIV_MAX(DIV_MAX),
    .GAP    (GAP)
  ) u_step (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eval_i     (eval_q),
    .ovl_pred_i (ovl_pred),
    .idle_pred_i(idle_pred[IP_W-1:0]),
    .ovl_thr_i  ($signed(ovl_thr_i)),
    .idle_thr_i (idle_thr_i),
    .done_i     (seq_done_i),
    .div_o      (div_o),
    .req_o      (div_req_o)
  );

  assign ovl_pred_o  = ovl_pred;
  assign idle_pred_o = idle_pred[IP_W-1:0];

  AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_done && !neg_q && !zero_q) |-> (quo <= NUM_W'(1 << FRAC_W))); // R1
  AST_IDLE_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_pred[IP_W]); // R3
endmodule

// File: tb/dvfs_governor_test.sv
`timescale 1ns/1ps
module dvfs_governor_test;
  localparam int GAP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] in_rate = '0, out_rate = '0;
  logic [7:0]  idle_cnt = '0, ovl_alpha = 8'd128, idle_alpha = 8'd128;
  logic [9:0]  ovl_thr = 10'd64;
  logic [11:0] idle_thr = 12'd32;
  logic        seq_done = 1'b0;
  logic [4:0]  div;
  logic        div_req;
  logic [9:0]  ovl_pred;
  logic [11:0] idle_pred;

  int errors = 0, checks = 0, req_cnt = 0;
  int m_ovl = 0, m_idle = 0, m_div = 2, m_gap = GAP - 1;
  bit m_first = 1'b1, m_wait = 1'b0, finished = 1'b0;

  always #4 clk = ~clk;

  dvfs_governor uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .in_rate_i(in_rate),
    .out_rate_i(out_rate), .idle_cnt_i(idle_cnt), .ovl_alpha_i(ovl_alpha),
    .idle_alpha_i(idle_alpha), .ovl_thr_i(ovl_thr), .idle_thr_i(idle_thr),
    .seq_done_i(seq_done), .div_o(div), .div_req_o(div_req),
    .ovl_pred_o(ovl_pred), .idle_pred_o(idle_pred)
  );

  always @(negedge clk) if (div_req) req_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ema(input int a, input int c, input int p);
    return (a * c + (256 - a) * p) >>> 8;
  endfunction

  function automatic int ratio(input int i, input int o);
    int q;
    if (i == 0) return 0;
    if (o <= i) return ((i - o) * 256) / i;
    q = ((o - i) * 256) / i;
    return -((q > 512) ? 512 : q);
  endfunction

  task automatic sample(input int i, input int o, input int idl, input bit hold);
    int r0, tgt, thr_s;
    bit chg;
    @(negedge clk);
    in_rate = 16'(i); out_rate = 16'(o); idle_cnt = 8'(idl); tick = 1'b1;
    r0 = req_cnt;
    @(negedge clk);
    tick = 1'b0;
    repeat (40) @(negedge clk);
    // R2, R3: predictor model
    if (m_first) begin
      m_ovl = 0; m_idle = 0; m_first = 1'b0;
    end else begin
      m_ovl  = ema(int'(ovl_alpha), ratio(i, o), m_ovl);   // R1
      m_idle = ema(int'(idle_alpha), idl * 16, m_idle);
    end
    thr_s = int'($signed(ovl_thr));
    if (m_idle > int'(idle_thr))  tgt = (m_div >= 16) ? 16 : m_div + 1; // R4
    else if (m_ovl > thr_s)       tgt = (m_div <= 2) ? 2 : m_div - 1;   // R5
    else                          tgt = m_div;
    chg = !m_wait && (m_gap >= GAP - 1) && (tgt != m_div);  // R6 R8 R9
    if (chg) begin
      m_div = tgt; m_gap = 0; m_wait = 1'b1;
    end else if (m_gap < GAP - 1) m_gap++;
    chk(int'($signed(ovl_pred)) == m_ovl, "R3 ovl_pred", int'($signed(ovl_pred)), m_ovl);
    chk(int'(idle_pred) == m_idle, "R3 idle_pred", int'(idle_pred), m_idle);
    chk(int'(div) == m_div, "R6 R8 div", int'(div), m_div);
    chk((req_cnt - r0) == (chg ? 1 : 0), "R7 req pulses", req_cnt - r0, chg ? 1 : 0);
    if (!hold) begin
      // R9: done when idle is harmless; done when waiting releases
      @(negedge clk) seq_done = 1'b1;
      @(negedge clk) seq_done = 1'b0;
      m_wait = 1'b0;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(div == 5'd2, "R10 div", int'(div), 2);
    chk(ovl_pred == '0, "R10 ovl_pred", int'(ovl_pred), 0);
    chk(idle_pred == '0, "R10 idle_pred", int'(idle_pred), 0);
    chk(div_req == 1'b0, "R10 req", int'(div_req), 0);
    rst_n = 1'b1;
    // R2: first sample leaves predictions at zero even with strong inputs
    sample(1000, 100, 20, 1'b0);
    chk(ovl_pred == '0 && idle_pred == '0, "R2 first sample", int'(idle_pred), 0);
    // R4, R6: climb to the slow clamp
    for (int k = 0; k < 50; k++) sample(1000, 1000, 8, 1'b0);
    chk(div == 5'd16, "R6 upper clamp", int'(div), 16);
    // R5: overload with no idle brings it back down
    for (int k = 0; k < 60; k++) sample(1000, 400, 0, 1'b0);
    chk(div == 5'd2, "R6 lower clamp", int'(div), 2);
    // R5: overload with idle at threshold still holds (not > threshold) and drives fast
    for (int k = 0; k < 6; k++) sample(1000, 500, 2, 1'b0);
    // R1: zero input rate and saturating negative ratio
    for (int k = 0; k < 8; k++) sample(0, 5000, 0, 1'b0);
    for (int k = 0; k < 8; k++) sample(1, 60000, 0, 1'b0);
    chk(int'($signed(ovl_pred)) < 0, "R1 negative saturation", int'($signed(ovl_pred)), -1);
    // R9: withhold done across high-idle samples, then release
    for (int k = 0; k < 10; k++) sample(800, 800, 12, 1'b1);
    r0 = req_cnt;
    for (int k = 0; k < 4; k++) sample(800, 800, 12, 1'b1);
    chk(req_cnt == r0, "R9 held while waiting", req_cnt - r0, 0);
    @(negedge clk) seq_done = 1'b1;
    @(negedge clk) seq_done = 1'b0;
    m_wait = 1'b0;
    for (int k = 0; k < 4; k++) sample(800, 800, 12, 1'b0);
    // R3 R4 R5 R8 R9: sweep over weights and thresholds
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        ovl_alpha  = (a == 0) ? 8'd1 : (a == 1) ? 8'd128 : 8'd255;
        idle_alpha = (b == 0) ? 8'd1 : (b == 1) ? 8'd77 : 8'd255;
        for (int k = 0; k < 100; k++) begin
          int ir, orr;
          ovl_thr  = 10'($signed(int'($urandom_range(0, 300)) - 100));
          idle_thr = 12'($urandom_range(0, 160));
          ir  = ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(1, 65535));
          orr = int'($urandom_range(0, 65535));
          if ($urandom_range(0, 1) == 1 && ir > 0) orr = ir - int'($urandom_range(0, ir));
          sample(ir, orr, int'($urandom_range(0, 15)), $urandom_range(0, 7) == 0);
        end
      end
    end
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule